// File: doc/BRIEF.md
# Switch-Programmed Integer-N Loop Divider and Phase Detector

This block is the digital part of an integer-N frequency synthesizer loop. It runs on one fast logic clock. Two slow square waves are sampled as inputs: a 100 kHz reference and the tuned oscillator, which runs at twice the wanted output frequency. A fixed divide-by-ten stage turns the reference into a 10 kHz comparison square wave. A toggle stage halves the oscillator to give a symmetrical output. An 8-bit up-counter, advanced by that output, is returned to zero when every counter bit selected by an 8-bit switch word reads one. Switch bit i carries weight 2^i. For example, closing the bits worth 64, 32, 16 and 2 gives a divide ratio of 114. The valid tuning range of 500 to 1800 kHz in 10 kHz steps maps to ratios 50 to 180, but any nonzero word divides.

The divider is a three-state machine. It starts in DIV_HOLD, where an all-zero word keeps it. It moves to DIV_COUNT once the word is nonzero. On the output rising edge that makes the selected bits all ones, it moves to DIV_CLEAR. It then stays in DIV_CLEAR for a stretched reset of STRETCH logic clocks, holds the count at zero, and drives the feedback pulse high. After that it returns to DIV_COUNT. From DIV_COUNT, an all-zero word sends it back to DIV_HOLD.

The phase-frequency detector has four states:
- PFD_IDLE: neither pump is active.
- PFD_LEAD: entered on a comparison edge alone; the up pump is active.
- PFD_LAG: entered on a feedback edge alone; the down pump is active.
- PFD_COINC: entered from PFD_LEAD on a feedback edge, from PFD_LAG on a comparison edge, or from PFD_IDLE when both edges land together. Both pumps are active for one cycle, then the machine returns to PFD_IDLE.

Edges that arrive while the machine is in PFD_COINC are ignored. At lock, the only pump activity left is the narrow PFD_COINC pulse once per comparison period, plus any residual phase error.

Top module: `pll_synth_core`

## Requirements
- R1: `cmp_ref` rises once for every 10 rising edges of `ref_in`. It stays high for 5 `ref_in` periods of each 10.
- R2: `out_clk` toggles once per `osc_in` rising edge. Its period is two `osc_in` periods, and its high and low times are equal.
- R3: With a nonzero `sw_word` of value D, consecutive rises of `fb_pulse` are exactly D rises of `out_clk` apart. Each rise of `fb_pulse` falls in the same cycle as an `out_clk` rise. The count wraps when every counter bit whose `sw_word` bit (weight 2^i for bit i) is one reads one.
- R4: Each `fb_pulse` stays high for exactly STRETCH (default 2) clock cycles while the count is held at zero. This holds provided an `out_clk` half period is longer than STRETCH cycles.
- R5: While `sw_word` is zero, `fb_pulse` never rises.
- R6: A feedback edge with no pump active raises `pump_dn` until the next comparison edge. With feedback faster than the comparison rate, `pump_up` is never high without `pump_dn`. `pump_dn` only falls after a cycle with both pumps high.
- R7: A comparison edge with no pump active raises `pump_up` until the next feedback edge. With feedback slower than the comparison rate, `pump_dn` is never high without `pump_up`. `pump_up` only falls after a cycle with both pumps high.
- R8: When the opposite edge arrives, or both edges land in the same cycle, both pumps are high for exactly one cycle and then both are low. There is one such cycle per comparison or feedback period, whichever is slower.
- R9: While `rst_n` is low, `out_clk`, `cmp_ref`, `fb_pulse`, `pump_up` and `pump_dn` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Logic clock that samples both slow inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | 100 kHz reference square wave |
| osc_in | input | 1 | Oscillator square wave at twice the output frequency |
| sw_word | input | 8 | Switch word selecting the counter bits that end a count |
| out_clk | output | 1 | Halved oscillator, 50% duty |
| cmp_ref | output | 1 | Reference divided by ten |
| fb_pulse | output | 1 | Stretched feedback pulse at each wrap of the counter |
| pump_up | output | 1 | Charge-up request |
| pump_dn | output | 1 | Charge-down request |

## Verification
A comparison edge and a feedback edge can fall in the same logic cycle, so the detector can move from PFD_IDLE straight to PFD_COINC without passing through PFD_LEAD or PFD_LAG. To provoke this, the bench sets the feedback rate equal to the comparison rate and restarts the oscillator at twelve successive clock offsets. This sweeps the phase between the two edges across the coincidence point. For each offset, the bench judges that exactly one both-high cycle occurs per comparison period and that no two such cycles are adjacent.

// File: rtl/pllc_pkg.sv
package pllc_pkg;

    typedef enum logic [1:0] {
        DIV_HOLD  = 2'd0,
        DIV_COUNT = 2'd1,
        DIV_CLEAR = 2'd2
    } div_state_t;

    typedef enum logic [1:0] {
        PFD_IDLE  = 2'd0,
        PFD_LEAD  = 2'd1,
        PFD_LAG   = 2'd2,
        PFD_COINC = 2'd3
    } pfd_state_t;

endpackage

// File: rtl/pllc_edge_sync.sv
module pllc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= {sh_q[STAGES-1:0], din};
        end
    end

    // rising edge seen after the synchronising stages
    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/pllc_ref_div.sv
module pllc_ref_div #(
    parameter int RATIO = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic cmp_lvl,
    output logic cmp_edge
);
    localparam int CW   = (RATIO > 2) ? $clog2(RATIO) : 1;
    localparam int HALF = RATIO / 2;
    localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

    logic [CW-1:0] cnt_q, cnt_d;
    logic          lvl_q, lvl_d;
    logic          edge_q, edge_d;

    always_comb begin
        cnt_d  = cnt_q;
        lvl_d  = lvl_q;
        edge_d = 1'b0;
        if (tick) begin
            cnt_d  = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
            lvl_d  = (cnt_d < CW'(HALF));
            edge_d = (cnt_q == LAST);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= LAST;
            lvl_q  <= 1'b0;
            edge_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            lvl_q  <= lvl_d;
            edge_q <= edge_d;
        end
    end

    assign cmp_lvl  = lvl_q;
    assign cmp_edge = edge_q;
endmodule

// File: rtl/pllc_fb_div.sv
module pllc_fb_div
    import pllc_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int STRETCH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_rise,
    input  logic [CNT_W-1:0] sw,
    output logic             out_lvl,
    output logic             fb_lvl,
    output logic             fb_edge
);
    localparam int HW = (STRETCH > 1) ? $clog2(STRETCH) : 1;
    localparam logic [HW-1:0] HOLD_LAST = HW'(STRETCH - 1);

    div_state_t       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [HW-1:0]    hold_q, hold_d;
    logic             tog_q, tog_d;
    logic             out_rise;
    logic [CNT_W-1:0] cnt_inc;
    logic             hit;

    assign out_rise = osc_rise & ~tog_q;
    assign cnt_inc  = cnt_q + 1'b1;
    assign hit      = ((cnt_inc & sw) == sw);

    // next state
    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        hold_d = hold_q;
        tog_d  = tog_q ^ osc_rise;
        unique case (st_q)
            DIV_HOLD: begin
                cnt_d = '0;
                if (|sw) st_d = DIV_COUNT;
            end
            DIV_COUNT: begin
                if (sw == '0) begin
                    st_d  = DIV_HOLD;
                    cnt_d = '0;
                end else if (out_rise) begin
                    if (hit) begin
                        st_d   = DIV_CLEAR;
                        cnt_d  = '0;
                        hold_d = '0;
                    end else begin
                        cnt_d = cnt_inc;
                    end
                end
            end
            DIV_CLEAR: begin
                cnt_d = '0;
                if (hold_q == HOLD_LAST) st_d = DIV_COUNT;
                else hold_d = hold_q + 1'b1;
            end
            default: begin
                st_d  = DIV_HOLD;
                cnt_d = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= DIV_HOLD;
            cnt_q  <= '0;
            hold_q <= '0;
            tog_q  <= 1'b0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            hold_q <= hold_d;
            tog_q  <= tog_d;
        end
    end

    // outputs
    always_comb begin
        out_lvl = tog_q;
        fb_lvl  = (st_q == DIV_CLEAR);
        fb_edge = (st_q == DIV_CLEAR) && (hold_q == '0);
    end
endmodule

// File: rtl/pllc_pfd.sv
module pllc_pfd
    import pllc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ref_ev,
    input  logic fb_ev,
    output logic up,
    output logic dn
);
    pfd_state_t st_q, st_d;

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PFD_IDLE: begin
                if (ref_ev && fb_ev) st_d = PFD_COINC;
                else if (ref_ev)     st_d = PFD_LEAD;
                else if (fb_ev)      st_d = PFD_LAG;
            end
            PFD_LEAD:  if (fb_ev)  st_d = PFD_COINC;
            PFD_LAG:   if (ref_ev) st_d = PFD_COINC;
            PFD_COINC: st_d = PFD_IDLE;
            default:   st_d = PFD_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= PFD_IDLE;
        else        st_q <= st_d;
    end

    // outputs
    always_comb begin
        up = (st_q == PFD_LEAD) || (st_q == PFD_COINC);
        dn = (st_q == PFD_LAG)  || (st_q == PFD_COINC);
    end
endmodule

// File: rtl/pll_synth_core.sv
module pll_synth_core #(
    parameter int SYNC_STAGES = 2,
    parameter int REF_RATIO   = 10,
    parameter int CNT_W       = 8,
    parameter int STRETCH     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_in,
    input  logic             osc_in,
    input  logic [CNT_W-1:0] sw_word,
    output logic             out_clk,
    output logic             cmp_ref,
    output logic             fb_pulse,
    output logic             pump_up,
    output logic             pump_dn
);
    localparam int N_IN = 2;
    localparam int IX_REF = 0;
    localparam int IX_OSC = 1;

    logic [N_IN-1:0] raw_in;
    logic [N_IN-1:0] rise_ev;
    logic            cmp_edge;
    logic            fb_edge;

    assign raw_in = {osc_in, ref_in};

    for (genvar g = 0; g < N_IN; g++) begin : g_sync
        pllc_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw_in[g]),
            .rise (rise_ev[g])
        );
    end

    pllc_ref_div #(.RATIO(REF_RATIO)) ref_div_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (rise_ev[IX_REF]),
        .cmp_lvl (cmp_ref),
        .cmp_edge(cmp_edge)
    );

    pllc_fb_div #(.CNT_W(CNT_W), .STRETCH(STRETCH)) fb_div_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .osc_rise(rise_ev[IX_OSC]),
        .sw      (sw_word),
        .out_lvl (out_clk),
        .fb_lvl  (fb_pulse),
        .fb_edge (fb_edge)
    );

    pllc_pfd pfd_i (
        .clk   (clk),
        .rst_n (rst_n),
        .ref_ev(cmp_edge),
        .fb_ev (fb_edge),
        .up    (pump_up),
        .dn    (pump_dn)
    );
endmodule

// File: rtl/pll_synth_core_chk.sv
module pll_synth_core_chk #(
    parameter int CNT_W   = 8,
    parameter int STRETCH = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] sw_word,
    input logic             out_clk,
    input logic             fb_pulse,
    input logic             pump_up,
    input logic             pump_dn
);
    logic [7:0] hi_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        hi_len <= '0;
        else if (fb_pulse) hi_len <= hi_len + 1'b1;
        else               hi_len <= '0;
    end

    a_r3_fb_on_out_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fb_pulse) |-> $rose(out_clk));

    a_r4_stretch_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fb_pulse) |-> hi_len == 8'(STRETCH));

    a_r4_stretch_cap: assert property (@(posedge clk) disable iff (!rst_n)
        fb_pulse |-> hi_len < 8'(STRETCH));

    a_r5_zero_word_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sw_word) == '0) |-> !$rose(fb_pulse));

    a_r6_dn_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pump_dn) |-> $past(pump_up));

    a_r7_up_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pump_up) |-> $past(pump_dn));

    a_r8_coinc_single: assert property (@(posedge clk) disable iff (!rst_n)
        (pump_up && pump_dn) |=> (!pump_up && !pump_dn));
endmodule

bind pll_synth_core pll_synth_core_chk #(.CNT_W(CNT_W), .STRETCH(STRETCH)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .sw_word (sw_word),
    .out_clk (out_clk),
    .fb_pulse(fb_pulse),
    .pump_up (pump_up),
    .pump_dn (pump_dn)
);

// File: tb/pll_synth_core_tb_top.sv
module pll_synth_core_tb_top;
    localparam int STRETCH = 2;
    localparam int NDIV = 11;
    localparam int DIVS [NDIV] = '{1, 2, 3, 7, 50, 85, 114, 128, 170, 180, 255};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_in = 1'b0;
    logic       osc_in = 1'b0;
    logic [7:0] sw_word = 8'd0;
    logic       out_clk, cmp_ref, fb_pulse, pump_up, pump_dn;

    int n_chk = 0;
    int n_bad = 0;
    int osc_half = 2;
    bit osc_run = 1'b0;

    pll_synth_core dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .ref_in  (ref_in),
        .osc_in  (osc_in),
        .sw_word (sw_word),
        .out_clk (out_clk),
        .cmp_ref (cmp_ref),
        .fb_pulse(fb_pulse),
        .pump_up (pump_up),
        .pump_dn (pump_dn)
    );

    always #4 clk = ~clk;

    // reference: 16 clock period
    initial begin
        #2;
        forever #64 ref_in = ~ref_in;
    end

    // oscillator: restartable
    initial begin
        forever begin
            if (osc_run) begin
                #(osc_half * 8);
                osc_in = ~osc_in;
            end else begin
                osc_in = 1'b0;
                @(posedge osc_run);
            end
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        finish_run();
    end

    task automatic check_eq(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_min(string req, string what, int act, int lo);
        n_chk++;
        if (act < lo) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected at least %0d", req, what, act, lo);
        end
    endtask

    function automatic logic sig(int sel);
        case (sel)
            0: return cmp_ref;
            1: return out_clk;
            2: return fb_pulse;
            3: return ref_in;
            default: return osc_in;
        endcase
    endfunction

    task automatic wait_rise(int sel, int limit, output bit ok);
        logic p;
        p = sig(sel);
        ok = 1'b0;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (sig(sel) && !p) begin
                ok = 1'b1;
                break;
            end
            p = sig(sel);
        end
    endtask

    // called on the sample where trig rose; counts cnt_sel rises up to next trig rise
    task automatic measure(int trig, int cnt_sel, int limit,
                           output int rises, output int hi, output bit ok);
        logic pt, pc, t, c;
        bit in_hi;
        pt = 1'b1;
        pc = sig(cnt_sel);
        in_hi = 1'b1;
        hi = 1;
        rises = 0;
        ok = 1'b0;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            c = sig(cnt_sel);
            t = sig(trig);
            if (c && !pc) rises++;
            if (in_hi) begin
                if (t) hi++;
                else in_hi = 1'b0;
            end
            if (t && !pt) begin
                ok = 1'b1;
                break;
            end
            pt = t;
            pc = c;
        end
    endtask

    task automatic pfd_window(int n, output int up_only, output int dn_only,
                              output int both, output int maxrun);
        int run;
        up_only = 0;
        dn_only = 0;
        both = 0;
        maxrun = 0;
        run = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pump_up && !pump_dn) up_only++;
            if (pump_dn && !pump_up) dn_only++;
            if (pump_up && pump_dn) begin
                both++;
                run++;
                if (run > maxrun) maxrun = run;
            end else begin
                run = 0;
            end
        end
    endtask

    initial begin
        bit ok;
        int rises, hi, up_o, dn_o, bth, mx, fb_rises, fb_hi;
        logic pf;

        // R9: reset state
        osc_run = 1'b1;
        repeat (6) @(negedge clk);
        check_eq("R9", "out_clk in reset", int'(out_clk), 0);
        check_eq("R9", "cmp_ref in reset", int'(cmp_ref), 0);
        check_eq("R9", "fb_pulse in reset", int'(fb_pulse), 0);
        check_eq("R9", "pump_up in reset", int'(pump_up), 0);
        check_eq("R9", "pump_dn in reset", int'(pump_dn), 0);
        rst_n = 1'b1;

        // R1: reference divided by ten, five periods high
        wait_rise(0, 400, ok);
        check_eq("R1", "first cmp_ref rise seen", int'(ok), 1);
        measure(0, 3, 400, rises, hi, ok);
        check_eq("R1", "ref_in rises per cmp_ref period", rises, 10);
        check_eq("R1", "cmp_ref high cycles", hi, 80);

        // R2: halved oscillator, equal high/low
        wait_rise(1, 100, ok);
        measure(1, 4, 100, rises, hi, ok);
        check_eq("R2", "osc_in rises per out_clk period", rises, 2);
        check_eq("R2", "out_clk high cycles", hi, 2 * osc_half);

        // R3/R4: divisor sweep
        foreach (DIVS[k]) begin
            @(negedge clk);
            sw_word = 8'(DIVS[k]);
            wait_rise(2, 4300, ok);
            wait_rise(2, 4300, ok);
            check_eq("R3", "fb_pulse rising seen", int'(ok), 1);
            measure(2, 1, 4300, rises, hi, ok);
            check_eq("R3", $sformatf("out_clk rises per fb period, D=%0d", DIVS[k]), rises, DIVS[k]);
            check_eq("R4", $sformatf("fb_pulse high cycles, D=%0d", DIVS[k]), hi, STRETCH);
        end

        // R5: zero word gives no feedback
        @(negedge clk);
        sw_word = 8'd0;
        repeat (8) @(negedge clk);
        fb_rises = 0;
        fb_hi = 0;
        pf = fb_pulse;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (fb_pulse && !pf) fb_rises++;
            if (fb_pulse) fb_hi++;
            pf = fb_pulse;
        end
        check_eq("R5", "fb_pulse rises with zero word", fb_rises, 0);
        check_eq("R5", "fb_pulse high cycles with zero word", fb_hi, 0);

        // R6: feedback twice the comparison rate
        sw_word = 8'd10;
        repeat (800) @(negedge clk);
        pfd_window(1600, up_o, dn_o, bth, mx);
        check_eq("R6", "up-only cycles, fast feedback", up_o, 0);
        check_min("R6", "down-only cycles, fast feedback", dn_o, 700);
        check_eq("R8", "coincidence cycles, fast feedback", bth, 10);

        // R7: feedback half the comparison rate
        sw_word = 8'd40;
        repeat (800) @(negedge clk);
        pfd_window(1600, up_o, dn_o, bth, mx);
        check_eq("R7", "down-only cycles, slow feedback", dn_o, 0);
        check_min("R7", "up-only cycles, slow feedback", up_o, 700);
        check_eq("R8", "coincidence cycles, slow feedback", bth, 5);

        // R8: equal rates, oscillator restarted at a range of offsets
        sw_word = 8'd20;
        for (int off = 0; off < 12; off++) begin
            osc_run = 1'b0;
            repeat (20) @(negedge clk);
            repeat (off) @(negedge clk);
            osc_run = 1'b1;
            repeat (800) @(negedge clk);
            pfd_window(1600, up_o, dn_o, bth, mx);
            check_eq("R8", $sformatf("coincidence cycles at lock, offset %0d", off), bth, 10);
            check_eq("R8", $sformatf("longest both-high run, offset %0d", off), mx, 1);
        end

        finish_run();
    end
endmodule